// File: doc/BRIEF.md
# Banked Host Register File with Power-Down

This block is the host-side register window of a network controller. A 4-bit host offset reaches 32 byte registers, arranged as four sets of eight. The control set always sits at offsets 0 to 7. The upper half of the window, offsets 8 to 15, shows one of the other three sets: node address, hash table or buffer port. A two-bit field in control register 7 picks which one. A host access is either one byte or one 16-bit word. A word access always covers an even/odd register pair.

The same control register also carries the power-down bit, which is active low. The host first sets the transmit/receive disable bit in control register 6. It then writes a zero to the power-down bit, and the block drops its clock-enable output. While the block is powered down, every register keeps its value and every write is dropped. The one exception is a write that puts a one into the power-down bit, which restores the clock enable. A hardware reset also ends power-down, and it returns all registers to their reset values. The whole register state is presented in parallel for the functions behind each set.

Top module: `regbank_pd`

## Requirements
- R1: After hardware reset every register reads 0x00 except control register 7, which reads 0x20. `clk_en` is 1.
- R2: Offsets 0 to 7 always address control registers 0 to 7, whatever the bank-select value is.
- R3: Bank select is control register 7 bits 3:2. Value 00 maps the node-address set (set 1) to offsets 8 to 15. Value 01 maps the hash-table set (set 2). Values 10 and 11 both map the buffer-port set (set 3). A write at offsets 8 to 15 changes only the mapped set.
- R4: A byte access (`host_word`=0) writes `host_wdata[7:0]` to the addressed register. The read value is that register zero-extended to 16 bits.
- R5: A word access (`host_word`=1) ignores address bit 0. The even register is in bits 7:0 and the next odd register is in bits 15:8, for both reads and writes.
- R6: Writing 0 to control register 7 bit 5 while control register 6 bit 7 is already 1 enters power-down. In the next cycle `clk_en` is 0 and control register 7 bit 5 reads 0. The other bits of that write are stored.
- R7: A zero written to control register 7 bit 5 is refused when control register 6 bit 7 was 0 before the write. This includes a word write at offset 6 that sets bit 7 of control register 6 in the same access. Bit 5 stays 1 and the other written bits are stored.
- R8: While powered down, writes to any register are ignored and all contents are kept. Reads still return the stored contents.
- R9: While powered down, a write that places a 1 in control register 7 bit 5 sets `clk_en` to 1 in the next cycle. This can be a byte write at offset 7 or a word write at offset 6. All other bits carried by that write, including the whole control register 6 byte of a word write, are ignored.
- R10: A hardware reset during power-down ends it and restores the R1 reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert, synchronized release |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Write strobe, one write per cycle while high |
| host_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| host_rdata | output | 16 | Read data for the current address, combinational |
| bank_q | output | 256 | All registers: byte at bits [(set*8+reg)*8 +: 8] |
| clk_en | output | 1 | Internal clock enable, 0 while powered down |

## Verification
The window is tested by writing distinct byte values into the upper offsets under each of the four bank-select codes. Reading them back under other codes tells a correct mapping from a swapped or merged one, and it shows that codes 10 and 11 reach the same set. Word writes at even and odd offsets, followed by byte reads of both halves, show whether alignment and lane order are right.

The power-down sequence is tested with ordered writes. One write is refused because the disable bit is not yet set. One combined word write sets the disable bit and clears the power bit in the same access. The sequence then enters power-down, tries writes that must be dropped, and exits both through a byte wake, a word wake and a reset. Each of these steps separates the previous-value gating rule from a plain bit store.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned NSETS    = 4;
  localparam int unsigned NREGS    = 8;
  localparam int unsigned DW       = 8;
  localparam int unsigned SETW     = $clog2(NSETS);
  localparam int unsigned REGW     = $clog2(NREGS);
  localparam int unsigned AW       = REGW + 1;
  localparam int unsigned NTOT     = NSETS * NREGS;
  localparam int unsigned CTRL_SEL = 7;   // control register with bank select and power bit
  localparam int unsigned CTRL_DIS = 6;   // control register with link disable bit
  localparam int unsigned PWR_BIT  = 5;
  localparam int unsigned DIS_BIT  = 7;
  localparam int unsigned SEL_LSB  = 2;

  typedef enum logic [1:0] {
    SEL_NODE = 2'b00,
    SEL_HASH = 2'b01,
    SEL_BUF  = 2'b10,
    SEL_BUFX = 2'b11
  } bank_sel_e;

  // set that appears in the upper window for a given select code
  function automatic logic [SETW-1:0] win_set(input logic [1:0] sel);
    case (bank_sel_e'(sel))
      SEL_NODE: win_set = SETW'(1);
      SEL_HASH: win_set = SETW'(2);
      default:  win_set = SETW'(3);
    endcase
  endfunction
endpackage

// File: rtl/regbank_rstsync.sv
module regbank_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_n_s = stg2_q;
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
(
  input  logic [AW-1:0]   addr,
  input  logic            word,
  input  logic            wr,
  input  logic [1:0]      bank_sel,
  output logic [NTOT-1:0] raw_we,
  output logic [NTOT-1:0] hi_lane,
  output logic [SETW-1:0] acc_set,
  output logic [REGW-1:0] acc_lo
);
  logic [SETW-1:0] tset;
  logic [REGW-1:0] lo;

  always_comb begin
    tset = addr[AW-1] ? win_set(bank_sel) : '0;
    lo   = word ? {addr[REGW-1:1], 1'b0} : addr[REGW-1:0];
  end

  assign acc_set = tset;
  assign acc_lo  = lo;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    for (genvar r = 0; r < NREGS; r++) begin : g_reg
      localparam logic [SETW-1:0] SI = SETW'(s);
      localparam logic [REGW-1:0] RI = REGW'(r);
      logic hit;
      always_comb begin
        hit = (RI == lo) || (word && (RI == (lo | REGW'(1))));
        raw_we[s*NREGS+r]  = wr && (tset == SI) && hit;
        hi_lane[s*NREGS+r] = word && RI[0];
      end
    end
  end
endmodule

// File: rtl/regbank_pwr.sv
module regbank_pwr
  import regbank_pkg::*;
(
  input  logic [DW-1:0] dis_q,
  input  logic [DW-1:0] ctl_q,
  input  logic          ctl_we_raw,
  input  logic [DW-1:0] ctl_wbyte,
  output logic          ctl_we,
  output logic [DW-1:0] ctl_d,
  output logic          running
);
  logic run_cur;
  logic allow_down;

  always_comb begin
    run_cur    = ctl_q[PWR_BIT];
    allow_down = dis_q[DIS_BIT];
    ctl_we     = 1'b0;
    ctl_d      = ctl_q;
    if (run_cur) begin
      ctl_we = ctl_we_raw;
      ctl_d  = ctl_wbyte;
      ctl_d[PWR_BIT] = ctl_wbyte[PWR_BIT] | ~allow_down;
    end else begin
      ctl_we = ctl_we_raw & ctl_wbyte[PWR_BIT];
      ctl_d[PWR_BIT] = 1'b1;
    end
  end

  assign running = run_cur;
endmodule

// File: rtl/regbank_set.sv
module regbank_set
  import regbank_pkg::*;
#(
  parameter logic [NREGS*DW-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREGS-1:0]    we,
  input  logic [NREGS*DW-1:0] wd,
  output logic [NREGS*DW-1:0] q
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic [DW-1:0] q_r, d_r;

    always_comb begin
      d_r = q_r;
      if (we[r]) d_r = wd[r*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_r <= RST_VAL[r*DW +: DW];
      else if (we[r]) q_r <= d_r;
    end

    assign q[r*DW +: DW] = q_r;
  end
endmodule

// File: rtl/regbank_pd.sv
module regbank_pd
  import regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      host_addr,
  input  logic [2*DW-1:0]    host_wdata,
  input  logic               host_wr,
  input  logic               host_word,
  output logic [2*DW-1:0]    host_rdata,
  output logic [NTOT*DW-1:0] bank_q,
  output logic               clk_en
);
  localparam int unsigned SEL_IDX = CTRL_SEL;
  localparam int unsigned DIS_IDX = CTRL_DIS;
  localparam logic [NREGS*DW-1:0] CTRL_RST =
    (NREGS*DW)'(1) << (SEL_IDX*DW + PWR_BIT);

  logic                rst_n_s;
  logic [NTOT-1:0]     raw_we, hi_lane, we_all;
  logic [NTOT*DW-1:0]  wd_all, q_all;
  logic [SETW-1:0]     acc_set;
  logic [REGW-1:0]     acc_lo;
  logic [DW-1:0]       ctl_q, dis_q, ctl_wbyte, ctl_d;
  logic                ctl_we, running;
  logic [1:0]          bank_sel;

  regbank_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign ctl_q    = q_all[SEL_IDX*DW +: DW];
  assign dis_q    = q_all[DIS_IDX*DW +: DW];
  assign bank_sel = ctl_q[SEL_LSB +: 2];

  regbank_decode u_dec (
    .addr(host_addr), .word(host_word), .wr(host_wr), .bank_sel(bank_sel),
    .raw_we(raw_we), .hi_lane(hi_lane), .acc_set(acc_set), .acc_lo(acc_lo)
  );

  assign ctl_wbyte = hi_lane[SEL_IDX] ? host_wdata[2*DW-1:DW] : host_wdata[DW-1:0];

  regbank_pwr u_pwr (
    .dis_q(dis_q), .ctl_q(ctl_q), .ctl_we_raw(raw_we[SEL_IDX]),
    .ctl_wbyte(ctl_wbyte), .ctl_we(ctl_we), .ctl_d(ctl_d), .running(running)
  );

  for (genvar i = 0; i < NTOT; i++) begin : g_wr
    if (i == SEL_IDX) begin : g_ctl
      assign we_all[i]          = ctl_we;
      assign wd_all[i*DW +: DW] = ctl_d;
    end else begin : g_plain
      assign we_all[i]          = raw_we[i] & running;
      assign wd_all[i*DW +: DW] = hi_lane[i] ? host_wdata[2*DW-1:DW] : host_wdata[DW-1:0];
    end
  end

  for (genvar s = 0; s < NSETS; s++) begin : g_bank
    localparam logic [NREGS*DW-1:0] RV = (s == 0) ? CTRL_RST : '0;
    regbank_set #(.RST_VAL(RV)) u_set (
      .clk(clk), .rst_n(rst_n_s),
      .we(we_all[s*NREGS +: NREGS]),
      .wd(wd_all[s*NREGS*DW +: NREGS*DW]),
      .q(q_all[s*NREGS*DW +: NREGS*DW])
    );
  end

  logic [SETW+REGW-1:0] rd_base, rd_next;
  always_comb begin
    rd_base = {acc_set, acc_lo};
    rd_next = rd_base | (SETW+REGW)'(1);
    host_rdata[DW-1:0]    = q_all[rd_base*DW +: DW];
    host_rdata[2*DW-1:DW] = host_word ? q_all[rd_next*DW +: DW] : '0;
  end

  assign bank_q = q_all;
  assign clk_en = running;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
(
  input logic               clk,
  input logic               rst_n_s,
  input logic [AW-1:0]      host_addr,
  input logic [2*DW-1:0]    host_wdata,
  input logic               host_wr,
  input logic               host_word,
  input logic [2*DW-1:0]    host_rdata,
  input logic [NTOT*DW-1:0] bank_q,
  input logic               clk_en
);
  localparam int unsigned PWR_POS = CTRL_SEL*DW + PWR_BIT;
  localparam int unsigned DIS_POS = CTRL_DIS*DW + DIS_BIT;
  localparam logic [NTOT*DW-1:0] KEEP = ~((NTOT*DW)'(1) << PWR_POS);

  logic wake_wr;
  assign wake_wr = host_wr && (host_addr[AW-1:1] == 3'b011) &&
                   (host_word ? host_wdata[DW+PWR_BIT] : (host_addr[0] && host_wdata[PWR_BIT]));

  p_entry_gated_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(clk_en) |-> $past(bank_q[DIS_POS]));

  p_hold_in_pd_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !clk_en |=> $stable(bank_q & KEEP));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!clk_en && wake_wr) |=> clk_en);

  p_ctrl_byte_read_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!host_word && !host_addr[AW-1]) |->
      (host_rdata == {8'h00, bank_q[int'(host_addr[2:0])*DW +: DW]}));

  p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clk_en && bank_q[DIS_POS] && host_wr && !host_word && host_addr == 4'd7 &&
     !host_wdata[PWR_BIT]) |=> !clk_en);
endmodule

bind regbank_pd regbank_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_wr(host_wr), .host_word(host_word), .host_rdata(host_rdata),
  .bank_q(bank_q), .clk_en(clk_en)
);

// File: tb/regbank_pd_tb.sv
`timescale 1ns/1ps
module regbank_pd_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   host_addr = '0;
  logic [15:0]  host_wdata = '0;
  logic         host_wr = 1'b0;
  logic         host_word = 1'b0;
  logic [15:0]  host_rdata;
  logic [255:0] bank_q;
  logic         clk_en;

  always #4 clk = ~clk;

  regbank_pd dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_word(host_word), .host_rdata(host_rdata),
    .bank_q(bank_q), .clk_en(clk_en)
  );

  int    n_cmp = 0, n_bad = 0;
  int    mem [32];
  int    rcnt = 0;
  string cur_req = "R1";
  bit    done = 0;

  function automatic int win(int off, int sel);
    int s;
    if (off < 8) s = 0;
    else if (sel == 0) s = 1;
    else if (sel == 1) s = 2;
    else s = 3;
    return s*8 + (off % 8);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mem[i] = 0;
    mem[7] = 8'h20;
  endtask

  task automatic model_write();
    int nm [32];
    int run, sel, dis, n, idx, v;
    int offs [2];
    int byts [2];
    for (int i = 0; i < 32; i++) nm[i] = mem[i];
    run = (mem[7] >> 5) & 1;
    sel = (mem[7] >> 2) & 3;
    dis = (mem[6] >> 7) & 1;
    if (host_word) begin
      n = 2; offs[0] = int'(host_addr) & 14; offs[1] = offs[0] + 1;
      byts[0] = int'(host_wdata) & 255; byts[1] = int'(host_wdata) >> 8;
    end else begin
      n = 1; offs[0] = int'(host_addr); byts[0] = int'(host_wdata) & 255;
      offs[1] = 0; byts[1] = 0;
    end
    for (int k = 0; k < n; k++) begin
      idx = win(offs[k], sel);
      if (idx == 7) begin
        if (run == 1) begin
          v = byts[k];
          if (((v & 32) == 0) && (dis == 0)) v = v | 32;
          nm[7] = v;
        end else if ((byts[k] & 32) != 0) nm[7] = mem[7] | 32;
      end else if (run == 1) nm[idx] = byts[k];
    end
    for (int i = 0; i < 32; i++) mem[i] = nm[i];
  endtask

  task automatic compare();
    int sel, base, exp_rd, exp_en, bad_i;
    sel  = (mem[7] >> 2) & 3;
    base = win(host_word ? (int'(host_addr) & 14) : int'(host_addr), sel);
    exp_rd = host_word ? (mem[base] | (mem[base+1] << 8)) : mem[base];
    exp_en = (mem[7] >> 5) & 1;
    n_cmp++;
    if (int'(host_rdata) != exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata addr=%0d word=%0b actual=%h expected=%h",
               cur_req, host_addr, host_word, host_rdata, exp_rd[15:0]);
    end
    n_cmp++;
    if (int'(clk_en) != exp_en) begin
      n_bad++;
      $display("FAIL %s clk_en actual=%0b expected=%0d", cur_req, clk_en, exp_en);
    end
    n_cmp++;
    bad_i = -1;
    for (int i = 0; i < 32; i++)
      if (bad_i < 0 && int'(bank_q[i*8 +: 8]) != mem[i]) bad_i = i;
    if (bad_i >= 0) begin
      n_bad++;
      $display("FAIL %s bank_q reg %0d actual=%h expected=%h",
               cur_req, bad_i, bank_q[bad_i*8 +: 8], mem[bad_i][7:0]);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin model_reset(); rcnt = 0; end
    else if (rcnt < 2) begin model_reset(); rcnt++; end
    else if (host_wr) model_write();
    #3;
    if (rst_n && rcnt >= 2 && !done) compare();
  end

  task automatic wr(input int a, input bit w, input int d, input string req);
    @(negedge clk);
    cur_req = req; host_addr = 4'(a); host_word = w; host_wdata = 16'(d); host_wr = 1'b1;
  endtask

  task automatic rd(input int a, input bit w, input string req);
    @(negedge clk);
    cur_req = req; host_addr = 4'(a); host_word = w; host_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8*200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 16; a++) rd(a, 0, "R1");
    // R4 byte writes to control set
    for (int a = 0; a < 6; a++) wr(a, 0, 16'hAB00 | (8'h11 * (a+1)), "R4");
    for (int a = 0; a < 8; a++) rd(a, 0, "R4");
    // R3 each bank-select code, distinct data per code
    for (int s = 0; s < 4; s++) begin
      wr(7, 0, 8'h20 | (s << 2), "R3");
      for (int a = 8; a < 16; a++) wr(a, 0, 8'h80 + s*16 + a, "R3");
      for (int a = 8; a < 16; a++) rd(a, 0, "R3");
    end
    for (int s = 0; s < 4; s++) begin
      wr(7, 0, 8'h20 | (s << 2), "R3");
      for (int a = 8; a < 16; a += 2) rd(a, 1, "R3");
    end
    // R2 low window independent of select
    for (int s = 0; s < 4; s++) begin
      wr(7, 0, 8'h20 | (s << 2), "R2");
      wr(2, 0, 8'hA0 + s, "R2");
      for (int a = 0; a < 8; a++) rd(a, 0, "R2");
    end
    // R5 word accesses
    wr(7, 0, 8'h24, "R5");
    wr(10, 1, 16'hBEEF, "R5");
    wr(13, 1, 16'h1234, "R5");
    rd(10, 1, "R5"); rd(11, 1, "R5"); rd(12, 1, "R5");
    rd(12, 0, "R5"); rd(13, 0, "R5"); rd(10, 0, "R5"); rd(11, 0, "R5");
    wr(0, 1, 16'hC3D4, "R5");
    rd(0, 1, "R5"); rd(1, 0, "R5");
    // R7 refused entry: disable bit clear, then combined word write
    wr(7, 0, 16'h0008, "R7");
    rd(7, 0, "R7"); rd(8, 0, "R7");
    wr(6, 1, 16'h0C80, "R7");
    rd(6, 1, "R7"); rd(7, 0, "R7");
    // R6 entry now allowed
    wr(7, 0, 16'h0004, "R6");
    rd(7, 0, "R6"); rd(6, 1, "R6");
    // R8 writes dropped while powered down
    wr(0, 0, 16'h00FF, "R8");
    wr(8, 1, 16'hFFFF, "R8");
    wr(6, 0, 16'h0000, "R8");
    wr(7, 0, 16'h001F, "R8");
    wr(6, 1, 16'h1F00, "R8");
    for (int a = 0; a < 16; a++) rd(a, 0, "R8");
    // R9 byte wake, other bits ignored
    wr(7, 0, 16'h00F3, "R9");
    rd(7, 0, "R9");
    wr(7, 0, 16'h0008, "R9");
    rd(7, 0, "R9");
    // R9 word wake at offset 6, control 6 byte ignored
    wr(6, 1, 16'h2000, "R9");
    rd(6, 1, "R9");
    wr(1, 0, 16'h0077, "R9");
    rd(1, 0, "R9");
    // R10 reset during power-down
    wr(7, 0, 16'h0000, "R10");
    rd(7, 0, "R10");
    @(negedge clk); rst_n = 1'b0; host_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 16; a++) rd(a, 0, "R10");
    wr(3, 0, 16'h005A, "R10");
    rd(3, 0, "R10");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule